// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block times the serial clock of an I2C master. It runs on the controller clock and holds two pairs of period counts, one for standard speed and one for fast speed. A speed select picks the pair in use. From the chosen pair it drives an open-drain pull-low request for SCL. It reads back a synchronized copy of the real SCL level, so a slave that holds the line low can stretch the clock.

The low phase starts counting in the same cycle the pull-low is asserted, not when the bus is seen low. The high phase does not begin counting until the bus reads high. It then adds a fixed internal overhead of eight cycles to the programmed count. A start request makes the block hold SCL high for a fixed time while the byte engine drops SDA. The block then gives a one-cycle completion flag, and SCL toggles until enable is removed. One-cycle ticks at each SCL edge let the shift logic place its data changes and samples.

Top module: `i2c_scl_timer`

## Requirements
- R1: With `fast_sel` = 1 the periods come from `fast_hi_cnt`/`fast_lo_cnt`. With `fast_sel` = 0 they come from `std_hi_cnt`/`std_lo_cnt`.
- R2: Each low phase keeps `scl_pull_low` asserted for exactly lo_eff + 1 consecutive cycles. It is counted from the first cycle of the pull-low, so the bus rises lo_eff + 1 cycles after `fall_tick`.
- R3: Without stretching, the next `fall_tick` comes exactly hi_eff + 8 cycles after a `rise_tick`.
- R4: Suppose `start_req` is sampled at a clock edge while idle and enabled. SCL then stays released for the next hi_eff + 3 cycles. `start_done` and the first `fall_tick` appear in the cycle after that.
- R5: After SCL is released, counting of the high phase waits while `scl_sync_in` reads low. `rise_tick` comes in the first cycle `scl_sync_in` reads high, and the hi_eff + 8 cycles run from there.
- R6: While `enable` is low, `scl_pull_low`, `busy` and all ticks are low in the same cycle, and `start_req` is ignored. After enable returns, the block is idle with fresh counters.
- R7: `fall_tick`, `rise_tick` and `start_done` are single-cycle pulses. They occur only at the moments R2 to R5 define, and `start_done` occurs only on the first fall after a start.
- R8: The effective high count hi_eff is the selected high count, or 6 if that is smaller. The effective low count lo_eff is the selected low count, or 8 if that is smaller.
- R9: `busy` is high from the cycle after an accepted start until enable drops. A `start_req` while busy leaves the clock schedule unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low releases SCL and clears the counters |
| fast_sel | input | 1 | 1 selects the fast count pair, 0 the standard pair |
| std_hi_cnt | input | CW | Standard-speed high count |
| std_lo_cnt | input | CW | Standard-speed low count |
| fast_hi_cnt | input | CW | Fast-speed high count |
| fast_lo_cnt | input | CW | Fast-speed low count |
| scl_sync_in | input | 1 | Synchronized SCL bus level |
| start_req | input | 1 | Request to begin a START hold and clocking |
| scl_pull_low | output | 1 | Drive SCL low when 1, release when 0 |
| start_done | output | 1 | One-cycle pulse: START hold finished, first fall now |
| fall_tick | output | 1 | One-cycle pulse on the first cycle of each low phase |
| rise_tick | output | 1 | One-cycle pulse when SCL is first seen high after release |
| busy | output | 1 | Clocking sequence in progress |

## Verification
All outputs decode directly from the state register, so each result appears in the cycle after the edge that causes it. Take a start sampled at edge k. `start_done` and the first `fall_tick` are due in cycle k + hi_eff + 4. The following `rise_tick` is due lo_eff + 1 + S cycles later, where S is the number of cycles the bench's slave model holds SCL low. The next `fall_tick` is due hi_eff + 8 cycles after that. The driver works out these cycle stamps from the programmed counts and queues them. A monitor samples at the falling clock edge and compares every observed event against the head of the queue, both kind and cycle, so any early, late, missing or extra edge is caught.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int CW     = 16,
  parameter int HI_MIN = 6,
  parameter int LO_MIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fast_sel,
  input  logic [CW-1:0] std_hi_cnt,
  input  logic [CW-1:0] std_lo_cnt,
  input  logic [CW-1:0] fast_hi_cnt,
  input  logic [CW-1:0] fast_lo_cnt,
  input  logic          scl_sync_in,
  input  logic          start_req,
  output logic          scl_pull_low,
  output logic          start_done,
  output logic          fall_tick,
  output logic          rise_tick,
  output logic          busy
);
  localparam int KW = CW + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_LOW, ST_HIGH} st_t;

  st_t           st;
  logic [KW-1:0] cnt;
  logic          from_hold;

  logic [CW-1:0] hi_sel, lo_sel, hi_eff, lo_eff;
  logic [KW-1:0] hold_last, low_last, high_last;

  assign hi_sel = fast_sel ? fast_hi_cnt : std_hi_cnt;
  assign lo_sel = fast_sel ? fast_lo_cnt : std_lo_cnt;
  assign hi_eff = (hi_sel < CW'(HI_MIN)) ? CW'(HI_MIN) : hi_sel;
  assign lo_eff = (lo_sel < CW'(LO_MIN)) ? CW'(LO_MIN) : lo_sel;

  // hold: hi+3 cycles, low: lo+1 cycles, high: hi+8 cycles (1+4+3 overhead)
  assign hold_last = {1'b0, hi_eff} + KW'(2);
  assign low_last  = {1'b0, lo_eff};
  assign high_last = {1'b0, hi_eff} + KW'(7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      from_hold <= 1'b0;
    end else if (!enable) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      from_hold <= 1'b0;
    end else begin
      from_hold <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (start_req) st <= ST_HOLD;
        end
        ST_HOLD: begin
          if (cnt >= hold_last) begin
            st        <= ST_LOW;
            cnt       <= '0;
            from_hold <= 1'b1;
          end else begin
            cnt <= cnt + KW'(1);
          end
        end
        ST_LOW: begin
          if (cnt >= low_last) begin
            st  <= ST_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + KW'(1);
          end
        end
        ST_HIGH: begin
          if (cnt != '0 || scl_sync_in) begin
            if (cnt >= high_last) begin
              st  <= ST_LOW;
              cnt <= '0;
            end else begin
              cnt <= cnt + KW'(1);
            end
          end
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign scl_pull_low = enable && (st == ST_LOW);
  assign fall_tick    = scl_pull_low && (cnt == '0);
  assign start_done   = fall_tick && from_hold;
  assign rise_tick    = enable && (st == ST_HIGH) && (cnt == '0) && scl_sync_in;
  assign busy         = enable && (st != ST_IDLE);
endmodule

// File: rtl/scl_timer_props.sv
module scl_timer_props (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic start_req,
  input logic scl_sync_in,
  input logic scl_pull_low,
  input logic start_done,
  input logic fall_tick,
  input logic rise_tick,
  input logic busy
);
  p_fall_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (scl_pull_low && !$past(scl_pull_low)));

  p_hold_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(busy)) |=> (!scl_pull_low && !start_done));

  p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (scl_sync_in && !scl_pull_low));

  p_reenable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(!enable)) |-> !busy);

  p_low_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $fell(scl_pull_low)) |-> $past(scl_pull_low, 9));
endmodule

bind i2c_scl_timer scl_timer_props u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .start_req    (start_req),
  .scl_sync_in  (scl_sync_in),
  .scl_pull_low (scl_pull_low),
  .start_done   (start_done),
  .fall_tick    (fall_tick),
  .rise_tick    (rise_tick),
  .busy         (busy)
);

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          fast_sel = 1'b0;
  logic [CW-1:0] std_hi_cnt = '0, std_lo_cnt = '0, fast_hi_cnt = '0, fast_lo_cnt = '0;
  logic          scl_sync_in;
  logic          start_req = 1'b0;
  logic          scl_pull_low, start_done, fall_tick, rise_tick, busy;

  i2c_scl_timer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .std_hi_cnt(std_hi_cnt), .std_lo_cnt(std_lo_cnt),
    .fast_hi_cnt(fast_hi_cnt), .fast_lo_cnt(fast_lo_cnt),
    .scl_sync_in(scl_sync_in), .start_req(start_req),
    .scl_pull_low(scl_pull_low), .start_done(start_done),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .busy(busy)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model: holds SCL low for stretch_amt cycles after each release
  int stretch_amt = 0;
  int sc = 0;
  assign scl_sync_in = !scl_pull_low && (sc == 0);
  always @(posedge clk) begin
    #2;
    if (scl_pull_low) sc = stretch_amt + 1;
    else if (sc > 0) sc = sc - 1;
  end

  typedef struct { int kind; int unsigned at; string req; } ev_t;
  ev_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void push(int kind, int unsigned at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endfunction

  // kinds: 0 start_done, 1 fall_tick, 2 rise_tick
  task automatic see(int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R7 unexpected event kind: actual %0d at cycle %0d expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        fails++;
        $display("FAIL %s event: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (start_done) see(0);
      if (fall_tick)  see(1);
      if (rise_tick)  see(2);
    end
  end

  task automatic drain(string req);
    int w = 0;
    while (exp_q.size() != 0 && w < 3000) begin
      @(posedge clk); #1;
      w++;
    end
    check(exp_q.size() == 0, req, "events still pending", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic burst(bit fast, int hi, int lo, int nper, int s, bit poke, string req);
    int he, le;
    int unsigned k, t;
    @(posedge clk); #1;
    fast_sel = fast;
    if (fast) begin fast_hi_cnt = CW'(hi); fast_lo_cnt = CW'(lo); end
    else      begin std_hi_cnt  = CW'(hi); std_lo_cnt  = CW'(lo); end
    stretch_amt = s;
    he = (hi < 6) ? 6 : hi;   // R8 clamps
    le = (lo < 8) ? 8 : lo;
    k = cyc;
    start_req = 1'b1;
    t = k + 1 + he + 3;       // R4 hold
    push(0, t, {req, "/R4 start_done"});
    push(1, t, {req, "/R4 first fall"});
    for (int p = 0; p < nper; p++) begin
      t = t + le + 1 + s;     // R2 low phase, R5 stretch
      push(2, t, (s > 0) ? {req, "/R5 rise"} : {req, "/R2 rise"});
      if (p < nper - 1) begin
        t = t + he + 8;       // R3 high phase
        push(1, t, {req, "/R3 fall"});
      end
    end
    @(posedge clk); #1;
    start_req = 1'b0;
    if (poke) begin
      check(busy == 1'b1, "R9", "busy after accepted start", busy, 1);
      repeat (2) begin @(posedge clk); #1; end
      start_req = 1'b1;
      @(posedge clk); #1;
      start_req = 1'b0;
    end
    drain(req);
    check(busy == 1'b1, "R9", "busy while clocking", busy, 1);
    enable = 1'b0;
    @(posedge clk); #1;
    enable = 1'b1;
    #1;
    check(busy == 1'b0, "R6", "idle after re-enable", busy, 0);
    stretch_amt = 0;
  endtask

  task automatic cut_test();
    int unsigned k, t;
    @(posedge clk); #1;
    fast_sel = 1'b0; std_hi_cnt = 16'd10; std_lo_cnt = 16'd20;
    k = cyc;
    start_req = 1'b1;
    t = k + 1 + 10 + 3;
    push(0, t, "R6/R4 start_done");
    push(1, t, "R6/R4 first fall");
    @(posedge clk); #1;
    start_req = 1'b0;
    drain("R6");
    check(scl_pull_low == 1'b1, "R2", "still low early in low phase", scl_pull_low, 1);
    enable = 1'b0;
    #1;
    check(scl_pull_low == 1'b0, "R6", "SCL released at once", scl_pull_low, 0);
    check(busy == 1'b0, "R6", "busy cleared at once", busy, 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      start_req = (i % 2 == 0);
    end
    @(posedge clk); #1;
    start_req = 1'b0;
    check(scl_pull_low == 1'b0, "R6", "start ignored while disabled", scl_pull_low, 0);
    enable = 1'b1;
    #1;
    check(busy == 1'b0, "R6", "idle after re-enable", busy, 0);
    repeat (30) begin @(posedge clk); #1; end
    check(busy == 1'b0, "R6", "no late start after re-enable", busy, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    fast_hi_cnt = 16'd7; fast_lo_cnt = 16'd9;
    std_hi_cnt  = 16'd10; std_lo_cnt = 16'd12;
    repeat (3) @(posedge clk);
    #1;
    rst_n  = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    check(scl_pull_low == 1'b0, "R6", "reset SCL released", scl_pull_low, 0);
    check(busy == 1'b0, "R9", "reset idle", busy, 0);
    check(fall_tick == 1'b0 && rise_tick == 1'b0 && start_done == 1'b0, "R7",
          "reset ticks", {fall_tick, rise_tick, start_done}, 0);

    // R1 standard pair, fast pair programmed differently
    fast_hi_cnt = 16'd7; fast_lo_cnt = 16'd9;
    burst(1'b0, 10, 12, 3, 0, 1'b0, "R1");
    // R1 fast pair, standard pair left at 10/12
    burst(1'b1, 7, 9, 3, 0, 1'b0, "R1");
    // R8 clamps below and at the minimums
    burst(1'b0, 2, 3, 2, 0, 1'b0, "R8");
    burst(1'b1, 5, 7, 2, 0, 1'b0, "R8");
    burst(1'b0, 6, 8, 2, 0, 1'b0, "R8");
    // R5 clock stretching
    burst(1'b0, 10, 12, 3, 4, 1'b0, "R5");
    burst(1'b1, 7, 9, 2, 1, 1'b0, "R5");
    // R9 start request while busy
    burst(1'b0, 9, 11, 2, 0, 1'b1, "R9");
    // R6 enable drop mid low phase, then a fresh run
    cut_test();
    burst(1'b0, 12, 15, 2, 0, 1'b0, "R6");

    repeat (5) @(posedge clk);
    check(exp_q.size() == 0, "R7", "queue empty at end", exp_q.size(), 0);
    finish_run();
  end
endmodule